// File: doc/BRIEF.md
# WAV Recording Stream Formatter

This block turns a run of 8-bit audio samples into the byte stream of one mono WAV file. A recording begins with a start pulse. The block first writes a 44-byte header to byte addresses 0 to 43. It then takes samples from a recording FIFO over a valid/ready handshake and writes each one to the next byte address, starting at 44. While it does this, it counts every sample byte it accepts.

The length of the recording is unknown until it ends, so the two size fields in the header are written first with the values for an empty file. A stop pulse closes the recording. The block then goes back and overwrites those two fields through the same addressed byte port, using eight single-byte writes. When the last of those writes has been taken, it raises `done` for one cycle. Each start after that opens a new file, with its own header and a count that begins again at zero.

Top module: `wav_stream_fmt`

## Requirements
- R1: While reset is high and in the first cycle after it, `w_valid`, `s_ready` and `done` are 0.
- R2: After a start pulse in the idle state, the first 44 byte writes go to addresses 0..43 in order. All multi-byte fields are little-endian. Their content is:
  - ASCII "RIFF" at 0.
  - A 32-bit chunk size of 36 at 4.
  - "WAVE" at 8 and "fmt " at 12.
  - The value 16 at 16.
  - Format code 1 (16-bit) at 20.
  - Channel count 1 (16-bit) at 22.
  - The sample-rate parameter (32-bit) at 24, and the same value as the byte rate at 28.
  - Block align 1 (16-bit) at 32.
  - Bits per sample 8 (16-bit) at 34.
  - "data" at 36.
  - A 32-bit data size of 0 at 40.
- R3: `s_ready` stays low until all 44 header bytes have been loaded. Each accepted sample is then written unchanged, in arrival order, to address 44 + k, where k is the number of samples accepted before it.
- R4: While `w_valid` is high and `w_ready` is low, `s_ready` is low, so no sample is lost or repeated.
- R5: While `w_valid` is high and `w_ready` is low, `w_valid`, `w_addr` and `w_data` keep their values into the next cycle.
- R6: After a stop, once all accepted samples have been written, exactly eight patch writes follow, to addresses 4, 5, 6, 7, 40, 41, 42, 43 in that order. They carry N+36 at address 4 and N at address 40, both little-endian, where N is the number of samples accepted. A sample accepted on the same edge that stop is sampled counts toward N.
- R7: `done` is high for exactly one cycle, in the cycle after the eighth patch byte is taken. The block is then idle, with `s_ready` low.
- R8: A stop that arrives while the header is being written is held. The whole header is still written, and the patch then follows with N = 0.
- R9: A start pulse during a recording and a stop pulse while idle have no effect on the written stream.
- R10: A start after `done` opens a new file, with a new header and a sample count starting from 0 at address 44.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse that opens a new recording |
| stop | input | 1 | Pulse that closes the recording |
| s_valid | input | 1 | Sample available from the FIFO |
| s_data | input | 8 | Sample byte |
| s_ready | output | 1 | Sample taken on this edge when `s_valid` is also high |
| w_valid | output | 1 | Byte write request |
| w_addr | output | ADDR_W | Byte address within the file |
| w_data | output | 8 | Byte to write |
| w_ready | input | 1 | Storage side accepts the write |
| done | output | 1 | One-cycle pulse when the header patch is complete |

## Verification
Two functions can fall on the same clock edge: the stop pulse can be sampled on the edge where the final sample is also taken. The bench provokes this by raising stop together with the last sample's `s_valid`, while `w_ready` is either steady or stalling at random. It records whether that sample was taken from `s_ready` seen before the edge. The patched size must then include the sample exactly when the bench saw it taken. A stop raised during the header, and a start raised in the middle of sample streaming, are judged the same way, against a scoreboard of addressed bytes.

// File: rtl/wavfmt_pkg.sv
package wavfmt_pkg;
  localparam int HDR_BYTES   = 44;
  localparam int PATCH_BYTES = 8;
  localparam int RIFF_EXTRA  = 36;
  localparam int SIZE_W      = 32;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_HDR   = 3'd1,
    ST_STRM  = 3'd2,
    ST_PATCH = 3'd3,
    ST_DRAIN = 3'd4
  } fmt_state_e;

  // Header offset touched by the k-th patch write
  function automatic logic [5:0] patch_offset(input logic [2:0] k);
    if (k < 3'd4) return 6'd4 + {3'd0, k};
    else          return 6'd36 + {3'd0, k};
  endfunction
endpackage

// File: rtl/wav_hdr_gen.sv
module wav_hdr_gen #(
  parameter int SAMPLE_RATE = 8000
) (
  input  logic [5:0]  idx,
  input  logic [31:0] data_size,
  output logic [7:0]  hbyte
);
  import wavfmt_pkg::*;

  localparam logic [31:0] SR = 32'(SAMPLE_RATE);

  logic [31:0] riff_size;
  assign riff_size = data_size + 32'(RIFF_EXTRA);

  always_comb begin
    case (idx)
      6'd0:  hbyte = 8'h52;
      6'd1:  hbyte = 8'h49;
      6'd2:  hbyte = 8'h46;
      6'd3:  hbyte = 8'h46;
      6'd4:  hbyte = riff_size[7:0];
      6'd5:  hbyte = riff_size[15:8];
      6'd6:  hbyte = riff_size[23:16];
      6'd7:  hbyte = riff_size[31:24];
      6'd8:  hbyte = 8'h57;
      6'd9:  hbyte = 8'h41;
      6'd10: hbyte = 8'h56;
      6'd11: hbyte = 8'h45;
      6'd12: hbyte = 8'h66;
      6'd13: hbyte = 8'h6d;
      6'd14: hbyte = 8'h74;
      6'd15: hbyte = 8'h20;
      6'd16: hbyte = 8'd16;
      6'd20: hbyte = 8'd1;
      6'd22: hbyte = 8'd1;
      6'd24: hbyte = SR[7:0];
      6'd25: hbyte = SR[15:8];
      6'd26: hbyte = SR[23:16];
      6'd27: hbyte = SR[31:24];
      6'd28: hbyte = SR[7:0];
      6'd29: hbyte = SR[15:8];
      6'd30: hbyte = SR[23:16];
      6'd31: hbyte = SR[31:24];
      6'd32: hbyte = 8'd1;
      6'd34: hbyte = 8'd8;
      6'd36: hbyte = 8'h64;
      6'd37: hbyte = 8'h61;
      6'd38: hbyte = 8'h74;
      6'd39: hbyte = 8'h61;
      6'd40: hbyte = data_size[7:0];
      6'd41: hbyte = data_size[15:8];
      6'd42: hbyte = data_size[23:16];
      6'd43: hbyte = data_size[31:24];
      default: hbyte = 8'h00;
    endcase
  end
endmodule

// File: rtl/wav_len_counter.sv
module wav_len_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (inc)   cnt <= cnt + 1'b1;
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (inc && !clr) |=> (cnt == $past(cnt) + 1'b1)); // R6
endmodule

// File: rtl/wav_out_slot.sv
module wav_out_slot #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [7:0]        ld_data,
  input  logic              w_ready,
  output logic              w_valid,
  output logic [ADDR_W-1:0] w_addr,
  output logic [7:0]        w_data,
  output logic              free
);
  assign free = !w_valid || w_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      w_valid <= 1'b0;
      w_addr  <= '0;
      w_data  <= '0;
    end else if (load) begin
      w_valid <= 1'b1;
      w_addr  <= ld_addr;
      w_data  <= ld_data;
    end else if (w_ready) begin
      w_valid <= 1'b0;
    end
  end

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (rst)
    (w_valid && !w_ready) |=> (w_valid && $stable(w_addr) && $stable(w_data))); // R5
endmodule

// File: rtl/wav_stream_fmt.sv
module wav_stream_fmt #(
  parameter int ADDR_W      = 32,
  parameter int SAMPLE_RATE = 8000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              stop,
  input  logic              s_valid,
  input  logic [7:0]        s_data,
  output logic              s_ready,
  output logic              w_valid,
  output logic [ADDR_W-1:0] w_addr,
  output logic [7:0]        w_data,
  input  logic              w_ready,
  output logic              done
);
  import wavfmt_pkg::*;

  localparam logic [5:0] LAST_HDR = 6'(HDR_BYTES - 1);
  localparam logic [2:0] LAST_PAT = 3'(PATCH_BYTES - 1);

  fmt_state_e        state;
  logic [5:0]        hdr_idx;
  logic [2:0]        pat_k;
  logic              stop_pend;
  logic [SIZE_W-1:0] count;
  logic              free;
  logic              take;
  logic              cnt_clr;
  logic              load;
  logic [ADDR_W-1:0] ld_addr;
  logic [7:0]        ld_data;
  logic [5:0]        gen_idx;
  logic [31:0]       gen_size;
  logic [7:0]        gen_byte;
  logic [31:0]       smp_addr;

  assign s_ready  = (state == ST_STRM) && !stop_pend && free;
  assign take     = s_valid && s_ready;
  assign cnt_clr  = (state == ST_IDLE) && start;
  assign smp_addr = 32'(HDR_BYTES) + count;

  // Patch pass reads the header generator with the final count
  always_comb begin
    if (state == ST_PATCH) begin
      gen_idx  = patch_offset(pat_k);
      gen_size = count;
    end else begin
      gen_idx  = hdr_idx;
      gen_size = '0;
    end
  end

  always_comb begin
    load    = 1'b0;
    ld_addr = '0;
    ld_data = gen_byte;
    case (state)
      ST_HDR: begin
        load    = free;
        ld_addr = ADDR_W'(hdr_idx);
      end
      ST_STRM: begin
        load    = take;
        ld_addr = ADDR_W'(smp_addr);
        ld_data = s_data;
      end
      ST_PATCH: begin
        load    = free;
        ld_addr = ADDR_W'(gen_idx);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      hdr_idx   <= '0;
      pat_k     <= '0;
      stop_pend <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      if ((state == ST_HDR || state == ST_STRM) && stop) stop_pend <= 1'b1;
      case (state)
        ST_IDLE: begin
          if (start) begin
            state     <= ST_HDR;
            hdr_idx   <= '0;
            stop_pend <= 1'b0;
          end
        end
        ST_HDR: begin
          if (free) begin
            if (hdr_idx == LAST_HDR) state <= ST_STRM;
            else                     hdr_idx <= hdr_idx + 1'b1;
          end
        end
        ST_STRM: begin
          if (stop_pend) begin
            state <= ST_PATCH;
            pat_k <= '0;
          end
        end
        ST_PATCH: begin
          if (free) begin
            if (pat_k == LAST_PAT) state <= ST_DRAIN;
            else                   pat_k <= pat_k + 1'b1;
          end
        end
        ST_DRAIN: begin
          if (w_valid && w_ready) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  wav_hdr_gen #(.SAMPLE_RATE(SAMPLE_RATE)) u_hdr (
    .idx       (gen_idx),
    .data_size (gen_size),
    .hbyte     (gen_byte)
  );

  wav_len_counter #(.W(SIZE_W)) u_cnt (
    .clk (clk),
    .rst (rst),
    .clr (cnt_clr),
    .inc (take),
    .cnt (count)
  );

  wav_out_slot #(.ADDR_W(ADDR_W)) u_slot (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .ld_addr (ld_addr),
    .ld_data (ld_data),
    .w_ready (w_ready),
    .w_valid (w_valid),
    .w_addr  (w_addr),
    .w_data  (w_data),
    .free    (free)
  );

  AST_NO_READ_STALL: assert property (@(posedge clk) disable iff (rst)
    (w_valid && !w_ready) |-> !s_ready); // R4
  AST_SAMPLE_PASS: assert property (@(posedge clk) disable iff (rst)
    (s_valid && s_ready) |=> (w_valid && w_data == $past(s_data))); // R3
  AST_DONE_ONE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R7
  AST_DONE_AFTER_XFER: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(w_valid && w_ready)); // R7
endmodule

// File: tb/tb_wav_stream_fmt.sv
module tb_wav_stream_fmt;
  localparam int SR = 8000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0, stop = 1'b0;
  logic        s_valid = 1'b0;
  logic [7:0]  s_data = '0;
  logic        s_ready;
  logic        w_valid;
  logic [31:0] w_addr;
  logic [7:0]  w_data;
  logic        w_ready = 1'b1;
  logic        done;

  int total = 0, bad = 0;
  int done_seen = 0;
  int nsmp = 0;
  bit rand_ready = 1'b0;
  bit sim_over = 1'b0;

  typedef struct packed { logic last; logic [31:0] addr; logic [7:0] data; } item_t;
  item_t q[$];

  always #4 clk = ~clk;

  wav_stream_fmt #(.ADDR_W(32), .SAMPLE_RATE(SR)) dut (
    .clk(clk), .rst(rst), .start(start), .stop(stop),
    .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
    .w_valid(w_valid), .w_addr(w_addr), .w_data(w_data),
    .w_ready(w_ready), .done(done)
  );

  function automatic logic [7:0] exp_hdr(input int i, input int n);
    logic [31:0] rs, ds, sr;
    string tag;
    rs = 32'(n + 36); ds = 32'(n); sr = 32'(SR);
    tag = "RIFF....WAVEfmt ";
    if (i < 4 || (i >= 8 && i < 16)) return tag[i];
    if (i >= 36 && i < 40) begin tag = "data"; return tag[i-36]; end
    if (i >= 4 && i < 8)   return rs[8*(i-4) +: 8];
    if (i >= 40 && i < 44) return ds[8*(i-40) +: 8];
    if (i >= 24 && i < 28) return sr[8*(i-24) +: 8];
    if (i >= 28 && i < 32) return sr[8*(i-28) +: 8];
    case (i)
      16: return 8'd16;
      20: return 8'd1;
      22: return 8'd1;
      32: return 8'd1;
      34: return 8'd8;
      default: return 8'd0;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string msg);
    total++;
    if (!ok) begin bad++; $display("FAIL %s: %s", req, msg); end
  endtask

  // w_ready driver
  always @(posedge clk) begin
    #1;
    w_ready = rand_ready ? ($urandom_range(0, 3) != 0) : 1'b1;
  end

  // Monitor: pops expected writes, checks stall rules and done timing
  logic        prev_stall = 1'b0;
  logic [31:0] prev_addr;
  logic [7:0]  prev_data;
  logic        done_exp = 1'b0;
  always @(negedge clk) begin
    if (!rst && !sim_over) begin
      if (done !== done_exp)
        check(1'b0, "R7", $sformatf("done act=%0b exp=%0b", done, done_exp));
      if (done) done_seen++;
      done_exp = 1'b0;
      if (prev_stall)
        check(w_valid && w_addr == prev_addr && w_data == prev_data, "R5",
              $sformatf("hold act=%0b/%0d/%02h exp=1/%0d/%02h", w_valid, w_addr, w_data,
                        prev_addr, prev_data));
      if (w_valid && !w_ready)
        check(!s_ready, "R4", $sformatf("s_ready act=%0b exp=0 during stall", s_ready));
      prev_stall = w_valid && !w_ready;
      prev_addr = w_addr; prev_data = w_data;
      if (w_valid && w_ready) begin
        if (q.size() == 0) begin
          check(1'b0, "R9", $sformatf("unexpected write act=%0d/%02h exp=none", w_addr, w_data));
        end else begin
          item_t it;
          it = q.pop_front();
          check(w_addr == it.addr && w_data == it.data, "R2/R3/R6",
                $sformatf("write act=%0d/%02h exp=%0d/%02h", w_addr, w_data, it.addr, it.data));
          done_exp = it.last;
        end
      end
    end
  end

  task automatic push_header();
    for (int i = 0; i < 44; i++) q.push_back('{1'b0, 32'(i), exp_hdr(i, 0)});
  endtask

  task automatic push_patch(input int n);
    for (int k = 0; k < 8; k++) begin
      int a;
      a = (k < 4) ? 4 + k : 36 + k;
      q.push_back('{(k == 7), 32'(a), exp_hdr(a, n)});
    end
  endtask

  task automatic pulse(input bit is_start);
    @(posedge clk); #1;
    if (is_start) start = 1'b1; else stop = 1'b1;
    @(posedge clk); #1;
    start = 1'b0; stop = 1'b0;
  endtask

  task automatic open_file();
    pulse(1'b1);
    push_header();
    nsmp = 0;
  endtask

  // Sends n samples; when stop_last, stop rises together with the final sample
  task automatic send(input int n, input int seed, input bit stop_last, input int start_at);
    for (int k = 0; k < n; k++) begin
      logic [7:0] d;
      d = 8'(seed + 37 * k);
      @(posedge clk); #1;
      s_valid = 1'b1; s_data = d;
      if (k == start_at) start = 1'b1;
      if (stop_last && k == n - 1) begin
        stop = 1'b1;
        @(negedge clk);
        if (s_ready) begin q.push_back('{1'b0, 32'(44 + nsmp), d}); nsmp++; end
        @(posedge clk); #1;
        stop = 1'b0; start = 1'b0; s_valid = 1'b0;
      end else begin
        forever begin
          @(negedge clk);
          if (s_ready) break;
          @(posedge clk); #1; start = 1'b0;
        end
        q.push_back('{1'b0, 32'(44 + nsmp), d});
        nsmp++;
        @(posedge clk); #1;
        start = 1'b0; s_valid = 1'b0;
      end
    end
  endtask

  task automatic wait_done(input string req);
    int t0;
    t0 = done_seen;
    for (int c = 0; c < 2000 && done_seen == t0; c++) @(posedge clk);
    repeat (2) @(posedge clk);
    check(done_seen == t0 + 1 && q.size() == 0, req,
          $sformatf("done count act=%0d exp=%0d, left act=%0d exp=0", done_seen - t0, 1, q.size()));
    @(negedge clk);
    check(!s_ready && !w_valid, "R7", $sformatf("idle act=%0b%0b exp=00", s_ready, w_valid));
  endtask

  initial begin
    #(200000 * 8);
    check(1'b0, "WATCHDOG", "timeout act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    check(!w_valid && !s_ready && !done, "R1", $sformatf("reset act=%0b%0b%0b exp=000", w_valid, s_ready, done));
    @(posedge clk); #1; rst = 1'b0;
    @(negedge clk);
    check(!w_valid && !s_ready && !done, "R1", $sformatf("post reset act=%0b%0b%0b exp=000", w_valid, s_ready, done));

    // R9: stop while idle is ignored
    pulse(1'b0);
    repeat (6) @(posedge clk);
    @(negedge clk);
    check(!w_valid && !s_ready, "R9", $sformatf("idle stop act=%0b%0b exp=00", w_valid, s_ready));

    // R2 R3 R6: plain recording, stop on the same edge as the last sample
    open_file();
    send(5, 3, 1'b1, -1);
    push_patch(nsmp);
    wait_done("R6");

    // R10 R9 R4 R5: new file, random stalls, start pulse in mid-stream
    rand_ready = 1'b1;
    open_file();
    send(20, 90, 1'b0, 10);
    pulse(1'b0);
    push_patch(nsmp);
    wait_done("R10");

    // R8: stop during header
    open_file();
    repeat (3) @(posedge clk);
    pulse(1'b0);
    push_patch(0);
    wait_done("R8");

    // Coincident stop and last sample under random stalls
    open_file();
    send(12, 200, 1'b1, -1);
    push_patch(nsmp);
    wait_done("R6");

    sim_over = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule